// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single counting channel of the kind found in a three-channel interval timer. A free-running tick enable advances an internal elapsed-tick count that restarts whenever a new initial count is loaded. The output bit is a pure function of that elapsed count, the loaded count and a 3-bit mode. The mode selects one of six output laws: terminal-count interrupt, one-shot, rate generator, square wave, software strobe and hardware strobe. A gate input can pause counting or retrigger the channel, depending on the mode.

The surrounding chip writes a new count and mode through a single load strobe. It reads back the remaining count, the stored mode and the sampled gate level. Byte-wide register access, command decoding and decimal counting belong to the wrapper around this channel. A parameter gives the channel's position in the group of three, and that position fixes the gate level the channel comes out of reset with.

Top module: `pit_channel`

## Requirements
- R1: After reset the stored mode is 3 (square wave) and the effective count is 65536. The elapsed count is zero, so `rd_count` reads 0 and `out` is high. The output stays high for the first 32768 ticks and then goes low.
- R2: The sampled gate level `rd_gate` resets to 1 when `CHAN_IDX` is 0 or 1, and to 0 when `CHAN_IDX` is 2.
- R3: A loaded count value of 0 is treated as 65536. Right after such a load `rd_count` reads 0, and one tick later it reads 65535.
- R4: In mode 0, `out` is low while elapsed < count and high from then on. It stays high.
- R5: In mode 1, `out` is high while elapsed < count and low from then on.
- R6: In mode 2, `out` is high for exactly the ticks where elapsed is a nonzero multiple of the count. It is low otherwise.
- R7: In mode 3, `out` is high while (elapsed mod count) < (count+1)/2, using integer division, and low otherwise. An odd count gives a high phase one tick longer than the low phase.
- R8: In modes 4 and 5, `out` is high only while elapsed equals the count. It is low before and after that, and it never comes back without a new load or retrigger.
- R9: Mode values 6 and 7 produce mode 0 behaviour in every respect. `rd_mode` still returns the value that was written.
- R10: A load strobe restarts elapsed at zero in the cycle it is taken, in every mode. It takes priority over a tick in the same cycle.
- R11: With `gate` low, ticks do not advance elapsed in modes 0, 2, 3 and 4 (and 6, 7). In modes 1 and 5 the gate level has no effect on counting.
- R12: A rising edge of `gate`, meaning high now and low in the previous cycle, restarts elapsed at zero in modes 1, 2, 3 and 5. It has no such effect in the other modes.
- R13: `rd_count` is the low 16 bits of the remaining count. In modes 2 and 3 that is count − (elapsed mod count). In the one-shot modes it is count − elapsed while elapsed < count, and 0 after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Counting tick enable, one cycle per tick |
| load | input | 1 | Load strobe for `load_count` and `load_mode` |
| load_mode | input | 3 | Mode written on load (0..7) |
| load_count | input | CNT_W | Initial count written on load (0 means 2^CNT_W) |
| gate | input | 1 | Gate level |
| out | output | 1 | Channel output |
| rd_count | output | CNT_W | Remaining count readback |
| rd_mode | output | 3 | Stored mode readback |
| rd_gate | output | 1 | Registered gate level |

## Verification
The elapsed counter is the one piece of hidden state, and `rd_count` exposes it in the cycle after every update. A missed tick, a wrong wrap point or a missing restart therefore shows up one clock later as a remaining-count mismatch, often before `out` changes at all. A wrong phase boundary in modes 2, 3, 4 and 5 is caught at the exact tick where `out` should change. A wrong saturation or gate rule shows as `out` or `rd_count` drifting from the reference over the following ticks. The bench keeps its own model of elapsed ticks that uses modulo arithmetic rather than a wrapping counter, and it compares both outputs after every cycle.

// File: rtl/pit_pkg.sv
// Shared mode encoding and mode-class helpers for the interval timer channel.
// Assumes a 3-bit mode field; codes 6 and 7 fold onto mode 0.
package pit_pkg;

    typedef enum logic [2:0] {
        PM_TERM    = 3'd0,
        PM_ONESHOT = 3'd1,
        PM_RATE    = 3'd2,
        PM_SQUARE  = 3'd3,
        PM_SWSTB   = 3'd4,
        PM_HWSTB   = 3'd5,
        PM_RSV6    = 3'd6,
        PM_RSV7    = 3'd7
    } pit_mode_e;

    // Map a raw mode code to the law it follows.
    function automatic pit_mode_e pit_eff_mode(input logic [2:0] raw);
        if (raw[2] && raw[1]) return PM_TERM;
        return pit_mode_e'(raw);
    endfunction

    // Modes whose elapsed count wraps every count ticks.
    function automatic logic pit_is_periodic(input pit_mode_e m);
        return (m == PM_RATE) || (m == PM_SQUARE);
    endfunction

    // Modes where a low gate freezes counting.
    function automatic logic pit_gate_holds(input pit_mode_e m);
        return (m == PM_TERM) || (m == PM_RATE) || (m == PM_SQUARE) || (m == PM_SWSTB);
    endfunction

    // Modes where a rising gate restarts the elapsed count.
    function automatic logic pit_edge_restarts(input pit_mode_e m);
        return (m == PM_ONESHOT) || (m == PM_RATE) || (m == PM_SQUARE) || (m == PM_HWSTB);
    endfunction

endpackage

// File: rtl/pit_gate_sync.sv
// Registers the gate level and flags its rising edge.
// Assumes the gate is already synchronous to clk; RST_LVL is the level held in reset.
module pit_gate_sync #(
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_in,
    output logic gate_q,
    output logic gate_rise
);

    // Hold the previous gate level for edge detection and readback.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= RST_LVL;
        else        gate_q <= gate_in;
    end

    // Rising edge means high now and low in the previous cycle.
    always_comb gate_rise = gate_in && !gate_q;

endmodule

// File: rtl/pit_elapsed.sv
// Holds the loaded count and the elapsed-tick counter of one channel.
// Periodic modes wrap the counter at count and remember that a wrap happened;
// one-shot modes saturate it at count+1 so the output settles for good.
// Assumes the mode input is stable between loads.
module pit_elapsed
    import pit_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int EFF_W = CNT_W + 1,
    localparam int ELW   = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_count,
    input  pit_mode_e        mode,
    input  logic             tick,
    input  logic             gate_in,
    input  logic             gate_rise,
    output logic [ELW-1:0]   elap_q,
    output logic [EFF_W-1:0] cnt_eff,
    output logic             wrap_q
);

    logic [CNT_W-1:0] cnt_q;
    logic [ELW-1:0]   cnt_ext;
    logic             restart;
    logic             step;

    // A zero count stands for 2^CNT_W.
    always_comb cnt_eff = {(cnt_q == '0), cnt_q};
    always_comb cnt_ext = {1'b0, cnt_eff};

    // Decide whether this cycle restarts or advances the counter.
    always_comb begin
        restart = gate_rise && pit_edge_restarts(mode);
        step    = tick && (gate_in || !pit_gate_holds(mode));
    end

    // Count register plus elapsed counter, load first, then retrigger, then tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            elap_q <= '0;
            wrap_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= load_count;
            elap_q <= '0;
            wrap_q <= 1'b0;
        end else if (restart) begin
            elap_q <= '0;
            wrap_q <= 1'b0;
        end else if (step) begin
            if (pit_is_periodic(mode)) begin
                if (elap_q == cnt_ext - 1'b1) begin
                    elap_q <= '0;
                    wrap_q <= 1'b1;
                end else begin
                    elap_q <= elap_q + 1'b1;
                end
            end else if (elap_q <= cnt_ext) begin
                elap_q <= elap_q + 1'b1;
            end
        end
    end

    AST_SAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !pit_is_periodic(mode) |-> (elap_q <= cnt_ext + 1'b1)); // R4

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pit_is_periodic(mode) |-> (elap_q < cnt_ext)); // R6

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (elap_q == '0)); // R10

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !gate_in && pit_gate_holds(mode)) |=> $stable(elap_q)); // R11

    AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && gate_rise && pit_edge_restarts(mode)) |=> (elap_q == '0)); // R12

endmodule

// File: rtl/pit_out_law.sv
// Combinational output law and remaining-count readback for one channel.
// Assumes elap_q < count in periodic modes and elap_q <= count+1 otherwise.
module pit_out_law
    import pit_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int EFF_W = CNT_W + 1,
    localparam int ELW   = CNT_W + 2
) (
    input  pit_mode_e        mode,
    input  logic [ELW-1:0]   elap_q,
    input  logic [EFF_W-1:0] cnt_eff,
    input  logic             wrap_q,
    output logic             out,
    output logic [CNT_W-1:0] rd_count
);

    logic [ELW-1:0] cnt_ext;
    logic [ELW-1:0] half;
    logic [ELW-1:0] remain;

    // Widen the count and form the rounded-up high phase length.
    always_comb begin
        cnt_ext = {1'b0, cnt_eff};
        half    = (cnt_ext + 1'b1) >> 1;
    end

    // Select the output law for the active mode.
    always_comb begin
        unique case (mode)
            PM_ONESHOT:        out = (elap_q < cnt_ext);
            PM_RATE:           out = (elap_q == '0) && wrap_q;
            PM_SQUARE:         out = (elap_q < half);
            PM_SWSTB, PM_HWSTB: out = (elap_q == cnt_ext);
            default:           out = (elap_q >= cnt_ext);
        endcase
    end

    // Remaining count: phase based when periodic, clamped at zero otherwise.
    always_comb begin
        if (pit_is_periodic(mode) || (elap_q < cnt_ext)) remain = cnt_ext - elap_q;
        else                                             remain = '0;
        rd_count = remain[CNT_W-1:0];
    end

endmodule

// File: rtl/pit_channel.sv
// One channel of an interval timer: mode register, gate sampling, elapsed
// counter and output law. CHAN_IDX sets the reset gate level (low for 2).
// Assumes tick, load and gate are synchronous to clk.
module pit_channel
    import pit_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int CHAN_IDX = 0,
    localparam int   EFF_W    = CNT_W + 1,
    localparam int   ELW      = CNT_W + 2,
    localparam logic RST_GATE = (CHAN_IDX != 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [2:0]       load_mode,
    input  logic [CNT_W-1:0] load_count,
    input  logic             gate,
    output logic             out,
    output logic [CNT_W-1:0] rd_count,
    output logic [2:0]       rd_mode,
    output logic             rd_gate
);

    logic [2:0]       mode_q;
    pit_mode_e        eff_mode;
    logic             gate_rise;
    logic [ELW-1:0]   elap_q;
    logic [EFF_W-1:0] cnt_eff;
    logic             wrap_q;

    // Stored raw mode, square wave after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    mode_q <= 3'd3;
        else if (load) mode_q <= load_mode;
    end

    // Fold reserved codes onto their law.
    always_comb eff_mode = pit_eff_mode(mode_q);
    always_comb rd_mode  = mode_q;

    pit_gate_sync #(.RST_LVL(RST_GATE)) i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_in   (gate),
        .gate_q    (rd_gate),
        .gate_rise (gate_rise)
    );

    pit_elapsed #(.CNT_W(CNT_W)) i_elapsed (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_count (load_count),
        .mode       (eff_mode),
        .tick       (tick),
        .gate_in    (gate),
        .gate_rise  (gate_rise),
        .elap_q     (elap_q),
        .cnt_eff    (cnt_eff),
        .wrap_q     (wrap_q)
    );

    pit_out_law #(.CNT_W(CNT_W)) i_law (
        .mode     (eff_mode),
        .elap_q   (elap_q),
        .cnt_eff  (cnt_eff),
        .wrap_q   (wrap_q),
        .out      (out),
        .rd_count (rd_count)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (rd_mode == 3'd3) && (rd_count == '0) && out); // R1

    AST_RESET_GATE: assert property (@(posedge clk)
        !rst_n |=> (rd_gate == RST_GATE)); // R2

    AST_STROBE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && out && ((eff_mode == PM_HWSTB) || ((eff_mode == PM_SWSTB) && gate)))
        |=> !out); // R8

endmodule

// File: tb/test_pit_channel.sv
module test_pit_channel;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic        load;
    logic [2:0]  lmode;
    logic [15:0] lcnt;
    logic        gate;

    logic        out0, out2;
    logic [15:0] rdc0, rdc2;
    logic [2:0]  rdm0, rdm2;
    logic        rdg0, rdg2;

    always #5 clk = ~clk;

    pit_channel #(.CNT_W(16), .CHAN_IDX(0)) i_pit_channel (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .load_mode(lmode),
        .load_count(lcnt), .gate(gate), .out(out0), .rd_count(rdc0),
        .rd_mode(rdm0), .rd_gate(rdg0)
    );

    pit_channel #(.CNT_W(16), .CHAN_IDX(2)) i_pit_channel_c2 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .load_mode(lmode),
        .load_count(lcnt), .gate(gate), .out(out2), .rd_count(rdc2),
        .rd_mode(rdm2), .rd_gate(rdg2)
    );

    typedef struct {
        string tag;
        bit    eo;
        int    ec;
    } exp_t;

    exp_t  sb[$];
    int    total = 0;
    int    bad   = 0;
    string cur   = "R1";

    // Reference model: unbounded elapsed ticks, laws in modulo form.
    int m_el  = 0;
    int m_cnt = 65536;
    int m_md  = 3;
    bit m_gp  = 1'b1;

    function automatic int eff(input int m);
        return (m >= 6) ? 0 : m;
    endfunction

    function automatic bit law_out();
        int e = eff(m_md);
        case (e)
            1:       return m_el < m_cnt;
            2:       return (m_el != 0) && ((m_el % m_cnt) == 0);
            3:       return (m_el % m_cnt) < ((m_cnt + 1) / 2);
            4, 5:    return m_el == m_cnt;
            default: return m_el >= m_cnt;
        endcase
    endfunction

    function automatic int law_cnt();
        int e = eff(m_md);
        if (e == 2 || e == 3) return (m_cnt - (m_el % m_cnt)) & 16'hFFFF;
        if (m_el < m_cnt)     return (m_cnt - m_el) & 16'hFFFF;
        return 0;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Driver: one clock of stimulus, then push the expected outputs.
    task automatic cyc(input bit tk, input bit ld, input int lv, input int lm, input bit g);
        int e;
        @(negedge clk);
        tick  = tk;
        load  = ld;
        lcnt  = lv[15:0];
        lmode = lm[2:0];
        gate  = g;
        @(posedge clk);
        #1;
        tick = 1'b0;
        load = 1'b0;
        e = eff(m_md);
        if (ld) begin
            m_el  = 0;
            m_cnt = (lv == 0) ? 65536 : lv;
            m_md  = lm;
        end else if (g && !m_gp && (e == 1 || e == 2 || e == 3 || e == 5)) begin
            m_el = 0;
        end else if (tk && (g || e == 1 || e == 5)) begin
            m_el++;
        end
        m_gp = g;
        sb.push_back('{cur, law_out(), law_cnt()});
    endtask

    // Monitor: pop expected items and compare at the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            total++;
            if (out0 !== it.eo) begin
                bad++;
                $display("FAIL %s out: got %0b expected %0b", it.tag, out0, it.eo);
            end
            total++;
            if (rdc0 !== it.ec[15:0]) begin
                bad++;
                $display("FAIL R13/%s rd_count: got %0d expected %0d", it.tag, rdc0, it.ec);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick = 1'b0; load = 1'b0; lmode = 3'd0; lcnt = 16'd0; gate = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 mode", int'(rdm0), 3);
        chk("R1 count", int'(rdc0), 0);
        chk("R1 out", int'(out0), 1);
        chk("R2 gate ch0", int'(rdg0), 1);
        chk("R2 gate ch2", int'(rdg2), 0);
        rst_n = 1'b1;

        cur = "R1";
        repeat (32770) cyc(1, 0, 0, 0, 1);

        cur = "R4";
        cyc(0, 1, 5, 0, 1);
        repeat (8) cyc(1, 0, 0, 0, 1);

        cur = "R11";
        cyc(0, 1, 4, 0, 1);
        repeat (2) cyc(1, 0, 0, 0, 1);
        repeat (4) cyc(1, 0, 0, 0, 0);
        repeat (4) cyc(1, 0, 0, 0, 1);

        cur = "R5";
        cyc(0, 1, 3, 1, 1);
        repeat (2) cyc(1, 0, 0, 0, 1);
        repeat (3) cyc(1, 0, 0, 0, 0);
        cur = "R12";
        cyc(0, 0, 0, 0, 1);
        repeat (4) cyc(1, 0, 0, 0, 1);

        cur = "R6";
        cyc(0, 1, 4, 2, 1);
        repeat (10) cyc(1, 0, 0, 0, 1);
        cur = "R11";
        repeat (3) cyc(1, 0, 0, 0, 0);
        cur = "R12";
        cyc(0, 0, 0, 0, 1);
        repeat (5) cyc(1, 0, 0, 0, 1);

        cur = "R7";
        cyc(0, 1, 5, 3, 1);
        repeat (12) cyc(1, 0, 0, 0, 1);
        cyc(0, 1, 6, 3, 1);
        repeat (8) cyc(1, 0, 0, 0, 1);
        cyc(0, 1, 1, 3, 1);
        repeat (3) cyc(1, 0, 0, 0, 1);
        cyc(0, 1, 3, 3, 1);
        for (int k = 0; k < 10; k++) cyc(k % 2 == 0, 0, 0, 0, 1);

        cur = "R8";
        cyc(0, 1, 3, 4, 1);
        repeat (8) cyc(1, 0, 0, 0, 1);
        cyc(0, 1, 2, 4, 1);
        cyc(1, 0, 0, 0, 1);
        repeat (3) cyc(1, 0, 0, 0, 0);
        repeat (3) cyc(1, 0, 0, 0, 1);
        cyc(0, 1, 2, 5, 1);
        repeat (5) cyc(1, 0, 0, 0, 1);
        cur = "R11";
        cyc(0, 1, 3, 5, 0);
        repeat (4) cyc(1, 0, 0, 0, 0);
        cur = "R12";
        cyc(0, 0, 0, 0, 1);
        repeat (4) cyc(1, 0, 0, 0, 1);

        cur = "R9";
        cyc(0, 1, 3, 6, 1);
        chk("R9 rd_mode 6", int'(rdm0), 6);
        repeat (5) cyc(1, 0, 0, 0, 1);
        cyc(0, 1, 2, 7, 1);
        chk("R9 rd_mode 7", int'(rdm0), 7);
        cyc(1, 0, 0, 0, 1);
        repeat (2) cyc(1, 0, 0, 0, 0);
        repeat (3) cyc(1, 0, 0, 0, 1);

        cur = "R3";
        cyc(0, 1, 0, 0, 1);
        repeat (3) cyc(1, 0, 0, 0, 1);

        cur = "R10";
        cyc(0, 1, 10, 2, 1);
        repeat (4) cyc(1, 0, 0, 0, 1);
        cyc(1, 1, 3, 0, 1);
        repeat (5) cyc(1, 0, 0, 0, 1);
        cyc(0, 1, 4, 3, 1);
        repeat (3) cyc(1, 0, 0, 0, 1);
        cyc(1, 1, 4, 3, 1);
        repeat (2) cyc(1, 0, 0, 0, 1);

        @(negedge clk);
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule